// File: doc/BRIEF.md
# Serial Register-Access Control Port

This block is the slave side of a four-wire serial control link. An external controller drives an active-low select, a bit clock and a data-in line. The block answers on a data-out line that it drives only when it is allowed to, and it marks those cycles with an output-enable. Behind the link sits a byte-wide register file that the rest of the chip reads through a plain index/data port. All link inputs are brought into the system clock domain by synchronizers. Bit-clock edges are then found by comparing consecutive synchronized samples, so the link clock must be several times slower than the system clock.

Every frame opens with a header byte. Its upper seven bits must match the block's fixed chip identifier and its lowest bit selects the direction. In a write frame the second byte loads a sticky register pointer and each later byte is stored at the register the pointer selects. The top bit of the pointer byte enables auto-increment and the lower bits form the register index. A read frame replays registers from the stored pointer. The usual way to read is therefore a write frame that stops right after the pointer byte, followed by a read frame. The block also latches a mode flag the first time select falls after reset.

Top module: `spi_ctl_port`

## Requirements
- R1: Data-in is captured on rising bit-clock edges; data-out changes only in response to falling bit-clock edges.
- R2: A header whose upper seven bits differ from the chip identifier (default 7'b1001111) makes the block ignore the rest of the frame: no register is written, the pointer is unchanged and the output-enable stays low.
- R3: Header bit 0 selects the direction: 0 starts a write frame, 1 starts a read frame.
- R4: In a write frame the second byte loads the pointer and every later complete byte is written to the register at the pointer index, visible on the config read port.
- R5: The output-enable stays low for the whole of a write frame.
- R6: Pointer bit 7 enables auto-increment and bits 6:0 are the register index. With bit 7 at 1 the index advances by one after each data byte read or written, wrapping from 127 to 0. With bit 7 at 0 the index stays fixed.
- R7: A write frame that ends right after the pointer byte changes only the pointer, and a following read frame starts at that index.
- R8: In a read frame the falling edge after the direction bit raises the output-enable and drives the MSB of the addressed register. The bytes follow MSB first and back to back.
- R9: Select going high ends any frame at once: the output-enable drops, the bit count restarts, and a partly shifted byte is discarded without a write.
- R10: Active-low reset clears every register and the mode flag. The mode flag goes high at the first select falling edge after reset and stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_cs_n | input | 1 | Link select, active low |
| spi_sclk | input | 1 | Link bit clock |
| spi_mosi | input | 1 | Link data from the controller |
| spi_miso | output | 1 | Link data to the controller |
| spi_miso_oe | output | 1 | High when spi_miso should be driven onto the pad |
| spi_mode | output | 1 | Mode flag, set by the first select falling edge |
| cfg_idx | input | 7 | Register index for on-chip read |
| cfg_data | output | 8 | Register contents at cfg_idx |

## Verification
The bench builds the block with its default values: 7-bit register index, byte-wide registers, identifier 7'b1001111 and two synchronizer stages. With these values the wrap from index 127 to 0 can be reached in a two-byte burst. Each link half-period is eight system clocks, which leaves room for the synchronizer and edge-detect latency before each sample point. A behavioural model holds the register image and the pointer. It predicts every byte read back and the full register image after each frame, while a per-clock monitor checks that the output-enable stays low wherever the model says no read is active.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PTR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } frame_st_e;
endpackage

// File: rtl/spi_ctl_sync_bit.sv
module spi_ctl_sync_bit #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_ctl_sync.sv
module spi_ctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sclk_i,
  input  logic mosi_i,
  output logic cs_n_o,
  output logic mosi_o,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_fall
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] raw, synced;
  logic            cs_prev, sclk_prev;

  assign raw = {mosi_i, sclk_i, cs_n_i};

  for (genvar i = 0; i < NSIG; i++) begin : g_sync
    spi_ctl_sync_bit #(
      .STAGES (STAGES),
      .RST_VAL((i == 0) ? 1'b1 : 1'b0)
    ) u_bit (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw[i]),
      .q    (synced[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev   <= 1'b1;
      sclk_prev <= 1'b0;
    end else begin
      cs_prev   <= synced[0];
      sclk_prev <= synced[1];
    end
  end

  assign cs_n_o    = synced[0];
  assign mosi_o    = synced[2];
  assign sclk_rise = synced[1] & ~sclk_prev;
  assign sclk_fall = ~synced[1] & sclk_prev;
  assign cs_fall   = ~synced[0] & cs_prev;
endmodule

// File: rtl/spi_ctl_regfile.sv
module spi_ctl_regfile #(
  parameter int IDX_W  = 7,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  a_idx,
  output logic [BYTE_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output logic [BYTE_W-1:0] b_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign a_data = mem[a_idx];
  assign b_data = mem[b_idx];

  // Checker state: remember the last write and confirm it landed.
  logic              chk_we;
  logic [IDX_W-1:0]  chk_idx;
  logic [BYTE_W-1:0] chk_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_we   <= 1'b0;
      chk_idx  <= '0;
      chk_data <= '0;
    end else begin
      chk_we   <= wr_en;
      chk_idx  <= wr_idx;
      chk_data <= wr_data;
    end
  end

  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_we |-> (b_idx != chk_idx) || (b_data == chk_data));
endmodule

// File: rtl/spi_ctl_frame.sv
module spi_ctl_frame
  import spi_ctl_pkg::*;
#(
  parameter int                 IDX_W   = 7,
  parameter int                 BYTE_W  = 8,
  parameter logic [BYTE_W-2:0]  CHIP_ID = 7'b1001111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              cs_fall,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_s,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              miso,
  output logic              miso_oe
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  frame_st_e         state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] shreg;
  logic [BYTE_W-1:0] ptr_q;
  logic [BYTE_W-1:0] tx_q;
  logic [BYTE_W-1:0] byte_in;
  logic              last_bit;
  logic              ptr_inc;
  logic [IDX_W-1:0]  ptr_idx;
  logic [IDX_W-1:0]  ptr_next;

  assign byte_in  = {shreg, mosi_s};
  assign last_bit = (bit_cnt == LAST_BIT);
  assign ptr_inc  = ptr_q[BYTE_W-1];
  assign ptr_idx  = ptr_q[IDX_W-1:0];
  assign ptr_next = ptr_idx + IDX_W'(1);

  // The read byte to load next: after the header it is the current index,
  // inside a read burst it is the index the pointer is about to take.
  assign rd_idx  = (state == ST_RDATA && ptr_inc) ? ptr_next : ptr_idx;

  assign wr_en   = sclk_rise && last_bit && !cs_n_s && (state == ST_WDATA);
  assign wr_idx  = ptr_idx;
  assign wr_data = byte_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      ptr_q   <= '0;
      tx_q    <= '0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else if (cs_n_s) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      miso_oe <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (cs_fall) begin
        state   <= ST_HDR;
        bit_cnt <= '0;
      end
    end else begin
      if (sclk_rise) begin
        shreg   <= byte_in[BYTE_W-2:0];
        bit_cnt <= last_bit ? '0 : bit_cnt + CNT_W'(1);
        if (last_bit) begin
          unique case (state)
            ST_HDR: begin
              if (byte_in[BYTE_W-1:1] != CHIP_ID) begin
                state <= ST_SKIP;
              end else if (byte_in[0]) begin
                state <= ST_RDATA;
                tx_q  <= rd_data;
              end else begin
                state <= ST_PTR;
              end
            end
            ST_PTR: begin
              ptr_q <= byte_in;
              state <= ST_WDATA;
            end
            ST_WDATA: begin
              if (ptr_inc) ptr_q[IDX_W-1:0] <= ptr_next;
            end
            ST_RDATA: begin
              if (ptr_inc) ptr_q[IDX_W-1:0] <= ptr_next;
              tx_q <= rd_data;
            end
            default: ;
          endcase
        end
      end
      if (sclk_fall && state == ST_RDATA) begin
        miso    <= tx_q[BYTE_W-1];
        tx_q    <= {tx_q[BYTE_W-2:0], 1'b0};
        miso_oe <= 1'b1;
      end
    end
  end

  p_miso_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> $past(sclk_fall));

  p_skip_inert_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> (!wr_en && !miso_oe));

  p_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PTR || state == ST_WDATA) |-> !miso_oe);

  p_fixed_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RDATA && !ptr_inc) |=> $stable(ptr_q));

  p_first_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RDATA && sclk_fall && !cs_n_s) |=> miso_oe);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !miso_oe);
endmodule

// File: rtl/spi_ctl_port.sv
module spi_ctl_port #(
  parameter int                IDX_W       = 7,
  parameter int                BYTE_W      = 8,
  parameter logic [BYTE_W-2:0] CHIP_ID     = 7'b1001111,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              spi_mode,
  input  logic [IDX_W-1:0]  cfg_idx,
  output logic [BYTE_W-1:0] cfg_data
);
  logic              cs_n_s, mosi_s, sclk_rise, sclk_fall, cs_fall;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic              mode_q;

  spi_ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_i   (spi_cs_n),
    .sclk_i   (spi_sclk),
    .mosi_i   (spi_mosi),
    .cs_n_o   (cs_n_s),
    .mosi_o   (mosi_s),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .cs_fall  (cs_fall)
  );

  spi_ctl_frame #(
    .IDX_W  (IDX_W),
    .BYTE_W (BYTE_W),
    .CHIP_ID(CHIP_ID)
  ) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_s   (cs_n_s),
    .cs_fall  (cs_fall),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .mosi_s   (mosi_s),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .miso     (spi_miso),
    .miso_oe  (spi_miso_oe)
  );

  spi_ctl_regfile #(
    .IDX_W (IDX_W),
    .BYTE_W(BYTE_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_data(wr_data),
    .a_idx  (rd_idx),
    .a_data (rd_data),
    .b_idx  (cfg_idx),
    .b_data (cfg_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (cs_fall) mode_q <= 1'b1;
  end

  assign spi_mode = mode_q;

  p_mode_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |=> mode_q);

  p_mode_needs_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q) |-> $past(cs_fall));
endmodule

// File: tb/spi_ctl_port_tb_top.sv
module spi_ctl_port_tb_top;
  localparam int HALF = 8;
  localparam logic [7:0] HDR_WR  = 8'h9E;
  localparam logic [7:0] HDR_RD  = 8'h9F;
  localparam logic [7:0] HDR_BAD = 8'h9C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
  logic       spi_miso, spi_miso_oe, spi_mode;
  logic [6:0] cfg_idx = '0;
  logic [7:0] cfg_data;

  int n_chk = 0, n_fail = 0;
  int mem[128];
  int ptr = 0;
  bit quiet = 1'b0;

  always #4 clk = ~clk;

  spi_ctl_port dut_i (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .spi_mode(spi_mode), .cfg_idx(cfg_idx), .cfg_data(cfg_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  // Per-clock monitor: output-enable must be low whenever no read is active.
  always @(negedge clk) begin
    if (quiet) chk(spi_miso_oe == 1'b0, "R5/R2/R9 oe low", spi_miso_oe, 0);
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits,
                      output logic [7:0] rx, output bit oe_all);
    rx = '0;
    oe_all = 1'b1;
    for (int i = 7; i >= 8 - nbits; i--) begin
      spi_mosi = tx[i];
      half();
      rx[i] = spi_miso;
      oe_all = oe_all & spi_miso_oe;
      spi_sclk = 1'b1;
      half();
      spi_sclk = 1'b0;
    end
  endtask

  task automatic cs_low();
    spi_cs_n = 1'b0;
    half();
  endtask

  task automatic cs_high();
    half();
    spi_cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
    quiet = 1'b1;
  endtask

  function automatic int adv(input int p);
    return (p & 128) ? (128 | ((p + 1) & 127)) : p;
  endfunction

  // Write frame: header, pointer byte, data bytes; last_bits < 8 leaves the final byte partial.
  task automatic wr_frame(input logic [7:0] hdr, input logic [7:0] p,
                          input logic [7:0] d[$], input int last_bits);
    logic [7:0] rx;
    bit oe;
    bit hit = (hdr[7:1] == 7'b1001111) && !hdr[0];
    quiet = 1'b1;
    cs_low();
    xfer(hdr, 8, rx, oe);
    xfer(p, 8, rx, oe);
    if (hit) ptr = p;
    foreach (d[k]) begin
      int nb = (k == d.size() - 1) ? last_bits : 8;
      xfer(d[k], nb, rx, oe);
      if (hit && nb == 8) begin
        mem[ptr & 127] = d[k];
        ptr = adv(ptr);
      end
    end
    cs_high();
  endtask

  task automatic rd_frame(input logic [7:0] hdr, input int nbytes, input string req);
    logic [7:0] rx;
    bit oe;
    bit hit = (hdr[7:1] == 7'b1001111) && hdr[0];
    quiet = !hit;
    cs_low();
    xfer(hdr, 8, rx, oe);
    for (int k = 0; k < nbytes; k++) begin
      xfer(8'h00, 8, rx, oe);
      if (hit) begin
        chk(rx == 8'(mem[ptr & 127]), req, rx, mem[ptr & 127]);
        chk(oe == 1'b1, "R8 oe high in read", oe, 1);
        ptr = adv(ptr);
      end
    end
    quiet = 1'b0;
    cs_high();
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 128; i++) begin
      cfg_idx = 7'(i);
      @(negedge clk);
      chk(cfg_data == 8'(mem[i]), req, cfg_data, mem[i]);
    end
  endtask

  initial begin
    logic [7:0] q[$];
    for (int i = 0; i < 128; i++) mem[i] = 0;
    repeat (10) @(negedge clk);
    chk(spi_mode == 1'b0, "R10 mode clear in reset", spi_mode, 0);
    chk(spi_miso_oe == 1'b0, "R9 oe low in reset", spi_miso_oe, 0);
    sweep("R10 regs clear");
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(spi_mode == 1'b0, "R10 mode waits for select fall", spi_mode, 0);
    quiet = 1'b1;

    // R4/R6: incrementing block write at index 0x10.
    q = '{8'hA1, 8'hB2, 8'hC3};
    wr_frame(HDR_WR, 8'h90, q, 8);
    chk(spi_mode == 1'b1, "R10 mode set", spi_mode, 1);
    sweep("R4 block write");

    // R6: fixed pointer write, 0x21 must stay clear.
    q = '{8'h11, 8'h22};
    wr_frame(HDR_WR, 8'h20, q, 8);
    sweep("R6 fixed pointer write");

    // R7/R8: pointer-only write then incrementing read.
    q = {};
    wr_frame(HDR_WR, 8'h90, q, 8);
    rd_frame(HDR_RD, 3, "R7 R8 read after pointer-only write");

    // R6/R3: fixed-pointer read repeats one register.
    wr_frame(HDR_WR, 8'h20, q, 8);
    rd_frame(HDR_RD, 2, "R6 R3 fixed read");

    // R2: wrong identifier, write and read both ignored.
    q = '{8'hFF, 8'hEE};
    wr_frame(HDR_BAD, 8'h90, q, 8);
    sweep("R2 bad id write ignored");
    rd_frame(8'h9D, 2, "R2 bad id read");
    rd_frame(HDR_RD, 1, "R2 pointer untouched");

    // R6: wrap 127 -> 0 on write and read.
    q = '{8'h5A, 8'h6B};
    wr_frame(HDR_WR, 8'hFF, q, 8);
    sweep("R6 write wrap");
    q = {};
    wr_frame(HDR_WR, 8'hFE, q, 8);
    rd_frame(HDR_RD, 3, "R6 read wrap");

    // R9: abort inside a data byte; pointer kept, partial byte dropped.
    q = '{8'h77, 8'h3C};
    wr_frame(HDR_WR, 8'h85, q, 4);
    sweep("R9 partial byte discarded");
    rd_frame(HDR_RD, 2, "R9 read after abort");

    // R1: alternating bit pattern through a fixed register.
    q = '{8'h5A};
    wr_frame(HDR_WR, 8'h40, q, 8);
    wr_frame(HDR_WR, 8'h40, '{}, 8);
    rd_frame(HDR_RD, 1, "R1 edge-aligned read");
    chk(spi_mode == 1'b1, "R10 mode sticky", spi_mode, 1);

    quiet = 1'b0;
    summary();
    $finish;
  end
endmodule